// File: doc/BRIEF.md
# CAN Error-State Interrupt Flag Register

This block holds the interrupt status byte of a CAN controller node. It watches the 9-bit transmit error count and the 8-bit receive error count every cycle. When a count enters a warning, error-passive or bus-off range, it raises a sticky flag. It also raises sticky flags on three single-cycle node events:
- an overload frame was sent,
- recovery from bus-off completed,
- reset processing completed.

Two further bits are not sticky. They copy, one cycle late, the OR of the receive-complete pending bits and the OR of the remote-request pending bits, each taken over the mailboxes whose receive interrupt is enabled. Software can only clear those two bits by servicing the mailboxes, not by writing this register.

Software reads the byte on `flags`. It clears sticky bits by pulsing `wr_en` with a 1 in each bit position to clear. An interrupt request `irq` is raised whenever any flag is set whose bit is also set in `irq_mask`. Every pin is plain control or status, so there is no stream interface and no back-pressure.

Top module: `can_err_irq_flags`

## Requirements
- R1: After reset `flags` is 8'h01: only bit 0 (reset done) is set.
- R2: Bit 3 (transmit warning) is set by the clock edge that samples `tec` at or above 96 after a cycle in which it was below 96.
- R3: Bit 4 (receive warning) is set by the clock edge that samples `rec` at or above 96 after a cycle in which it was below 96.
- R4: Bit 5 (error passive) is set by the clock edge at which the condition "`tec` at or above 128, or `rec` at or above 128" becomes true. A change that keeps the combined condition true does not set it again.
- R5: Bit 6 (bus off) is set by the clock edge that first samples `tec` at or above 256.
- R6: Bit 7 is set by the clock edge that samples `ovld_sent` or `busoff_recov` high.
- R7: Bit 0 is set by the clock edge that samples `reset_done` high.
- R8: A write (`wr_en` high) clears each of bits 7, 6, 5, 4, 3 and 0 for which `wr_data` holds a 1. Bits written with 0 keep their value.
- R9: A threshold flag cleared while its condition still holds stays clear. It sets again only after the condition has been left and re-entered.
- R10: When a set event and a write-1 clear hit the same bit in the same cycle, the bit ends up set.
- R11: Bit 1 equals `rx_pend_any` and bit 2 equals `rmt_pend_any`, each as sampled at the previous clock edge. Writes have no effect on either bit.
- R12: `irq` is high in the same cycle as, and only when, `flags & irq_mask` is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tec | input | 9 | Transmit error count |
| rec | input | 8 | Receive error count |
| ovld_sent | input | 1 | One-cycle pulse: an overload frame was sent |
| busoff_recov | input | 1 | One-cycle pulse: recovery from bus-off completed |
| reset_done | input | 1 | One-cycle pulse: reset processing completed |
| rx_pend_any | input | 1 | OR of receive-complete pending bits of enabled mailboxes |
| rmt_pend_any | input | 1 | OR of remote-request pending bits of enabled mailboxes |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write-1-to-clear data |
| irq_mask | input | 8 | Per-bit interrupt enable |
| flags | output | 8 | Flag byte, also the read data |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the event inputs are sampled only on clock edges, and that the pending inputs are already OR-reduced levels. They make no assumption about how fast the counts move. The threshold checks are written against the count's own crossing, so any jump between values is legal. The stimulus changes inputs only on the falling edge and drives each event as a single-cycle pulse. It moves the counts in jumps that enter, hold, leave and re-enter each range, including one jump that takes the transmit count from the warning range straight to bus-off.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
  localparam int FLAG_W = 8;
  localparam int B_RSTD = 0;
  localparam int B_RXP  = 1;
  localparam int B_RMT  = 2;
  localparam int B_TWRN = 3;
  localparam int B_RWRN = 4;
  localparam int B_PASV = 5;
  localparam int B_BOFF = 6;
  localparam int B_OVLD = 7;
  localparam logic [FLAG_W-1:0] STICKY_MASK = 8'b1111_1001;
  localparam logic [FLAG_W-1:0] RESET_FLAGS = 8'b0000_0001;
endpackage

// File: rtl/can_cnt_thresh.sv
module can_cnt_thresh #(
  parameter int W   = 9,
  parameter int LVL = 96
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt,
  output logic         rise
);
  localparam logic [W:0] LVL_X = (W+1)'(LVL);
  logic cond, cond_q;

  assign cond = {1'b0, cnt} >= LVL_X;

  always_ff @(posedge clk) begin
    if (!rst_n) cond_q <= 1'b0;
    else        cond_q <= cond;
  end

  assign rise = cond & ~cond_q;
endmodule

// File: rtl/can_flag_w1c.sv
module can_flag_w1c #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n)   q <= RST_VAL;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end
endmodule

// File: rtl/can_err_irq_flags.sv
module can_err_irq_flags
  import can_irq_pkg::*;
#(
  parameter int TEC_W    = 9,
  parameter int REC_W    = 8,
  parameter int WARN_LVL = 96,
  parameter int PASV_LVL = 128,
  parameter int BOFF_LVL = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TEC_W-1:0]  tec,
  input  logic [REC_W-1:0]  rec,
  input  logic              ovld_sent,
  input  logic              busoff_recov,
  input  logic              reset_done,
  input  logic              rx_pend_any,
  input  logic              rmt_pend_any,
  input  logic              wr_en,
  input  logic [FLAG_W-1:0] wr_data,
  input  logic [FLAG_W-1:0] irq_mask,
  output logic [FLAG_W-1:0] flags,
  output logic              irq
);
  localparam int CW = (TEC_W > REC_W) ? TEC_W : REC_W;
  localparam logic [CW:0] PASV_X = (CW+1)'(PASV_LVL);

  logic tw_rise, rw_rise, bo_rise;
  logic pasv_cond, pasv_q, pasv_rise;
  logic [FLAG_W-1:0] set_v, clr_v;
  logic rxp_q, rmt_q;

  can_cnt_thresh #(.W(TEC_W), .LVL(WARN_LVL)) u_tw (
    .clk(clk), .rst_n(rst_n), .cnt(tec), .rise(tw_rise));
  can_cnt_thresh #(.W(REC_W), .LVL(WARN_LVL)) u_rw (
    .clk(clk), .rst_n(rst_n), .cnt(rec), .rise(rw_rise));
  can_cnt_thresh #(.W(TEC_W), .LVL(BOFF_LVL)) u_bo (
    .clk(clk), .rst_n(rst_n), .cnt(tec), .rise(bo_rise));

  // error passive combines both counters before edge detection
  assign pasv_cond = ((CW+1)'(tec) >= PASV_X) | ((CW+1)'(rec) >= PASV_X);
  always_ff @(posedge clk) begin
    if (!rst_n) pasv_q <= 1'b0;
    else        pasv_q <= pasv_cond;
  end
  assign pasv_rise = pasv_cond & ~pasv_q;

  always_comb begin
    set_v         = '0;
    set_v[B_RSTD] = reset_done;
    set_v[B_TWRN] = tw_rise;
    set_v[B_RWRN] = rw_rise;
    set_v[B_PASV] = pasv_rise;
    set_v[B_BOFF] = bo_rise;
    set_v[B_OVLD] = ovld_sent | busoff_recov;
    clr_v         = wr_en ? (wr_data & STICKY_MASK) : '0;
  end

  genvar i;
  generate
    for (i = 0; i < FLAG_W; i++) begin : g_bit
      if (STICKY_MASK[i]) begin : g_w1c
        can_flag_w1c #(.RST_VAL(RESET_FLAGS[i])) u_f (
          .clk(clk), .rst_n(rst_n), .set(set_v[i]), .clr(clr_v[i]),
          .q(flags[i]));
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxp_q <= 1'b0;
      rmt_q <= 1'b0;
    end else begin
      rxp_q <= rx_pend_any;
      rmt_q <= rmt_pend_any;
    end
  end
  assign flags[B_RXP] = rxp_q;
  assign flags[B_RMT] = rmt_q;

  assign irq = |(flags & irq_mask);
endmodule

module can_err_irq_flags_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [8:0] tec,
  input logic [7:0] rec,
  input logic       ovld_sent,
  input logic       busoff_recov,
  input logic       reset_done,
  input logic       rx_pend_any,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] irq_mask,
  input logic [7:0] flags,
  input logic       irq
);
  // R2
  tw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tec >= 9'd96) |=> flags[3]);
  // R5
  bo_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tec >= 9'd256) |=> flags[6]);
  // R6
  ovld_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovld_sent || busoff_recov) |=> flags[7]);
  // R7
  rstd_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_done |=> flags[0]);
  // R8
  ovld_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[7] && !ovld_sent && !busoff_recov) |=> !flags[7]);
  // R8
  boff_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[6] && !(wr_en && wr_data[6])) |=> flags[6]);
  // R11
  rxp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (flags[1] == $past(rx_pend_any)));
  // R12
  irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mask == 8'h00) |-> !irq);
endmodule

bind can_err_irq_flags can_err_irq_flags_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tec(tec), .rec(rec), .ovld_sent(ovld_sent),
  .busoff_recov(busoff_recov), .reset_done(reset_done),
  .rx_pend_any(rx_pend_any), .wr_en(wr_en), .wr_data(wr_data),
  .irq_mask(irq_mask), .flags(flags), .irq(irq));

// File: tb/can_err_irq_flags_tb_top.sv
`timescale 1ns/1ps
module can_err_irq_flags_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] tec = '0;
  logic [7:0] rec = '0;
  logic ovld_sent = 0, busoff_recov = 0, reset_done = 0;
  logic rx_pend_any = 0, rmt_pend_any = 0, wr_en = 0;
  logic [7:0] wr_data = '0, irq_mask = '0;
  logic [7:0] flags;
  logic       irq;

  int errors = 0;
  int checks = 0;

  typedef struct {
    logic [7:0] fl;
    logic       iq;
    string      tag;
  } exp_t;
  exp_t sb_q[$];

  always #2 clk = ~clk;

  can_err_irq_flags dut_i (
    .clk(clk), .rst_n(rst_n), .tec(tec), .rec(rec), .ovld_sent(ovld_sent),
    .busoff_recov(busoff_recov), .reset_done(reset_done),
    .rx_pend_any(rx_pend_any), .rmt_pend_any(rmt_pend_any), .wr_en(wr_en),
    .wr_data(wr_data), .irq_mask(irq_mask), .flags(flags), .irq(irq));

  // driver: apply one cycle of stimulus and queue the expected result
  task automatic step(input logic [8:0] t, input logic [7:0] r,
                      input logic ov, input logic br, input logic rd,
                      input logic rx, input logic rm, input logic we,
                      input logic [7:0] wd, input logic [7:0] mk,
                      input logic [7:0] exp_fl, input string tag);
    exp_t e;
    @(negedge clk);
    tec = t; rec = r; ovld_sent = ov; busoff_recov = br; reset_done = rd;
    rx_pend_any = rx; rmt_pend_any = rm; wr_en = we; wr_data = wd;
    irq_mask = mk;
    e.fl = exp_fl; e.iq = |(exp_fl & mk); e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor: compare after each rising edge
  always @(posedge clk) begin
    #1;
    if (rst_n && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (flags !== e.fl) begin
        errors++;
        $display("FAIL %s flags actual=%h expected=%h", e.tag, flags, e.fl);
      end
      checks++;
      if (irq !== e.iq) begin
        errors++;
        $display("FAIL %s irq actual=%b expected=%b", e.tag, irq, e.iq);
      end
    end
  end

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    checks++;
    if (flags !== 8'h01) begin
      errors++;
      $display("FAIL R1 reset actual=%h expected=01", flags);
    end
    //    tec     rec     ov br rd rx rm we wd     mask   exp
    step(9'd0,   8'd0,   0, 0, 0, 0, 0, 0, 8'h00, 8'h00, 8'h01, "R1");
    step(9'd0,   8'd0,   0, 0, 0, 0, 0, 1, 8'h01, 8'h00, 8'h00, "R8");
    step(9'd96,  8'd0,   0, 0, 0, 0, 0, 0, 8'h00, 8'h00, 8'h08, "R2");
    step(9'd96,  8'd0,   0, 0, 0, 0, 0, 1, 8'h08, 8'h00, 8'h00, "R9");
    step(9'd96,  8'd0,   0, 0, 0, 0, 0, 0, 8'h00, 8'h00, 8'h00, "R9");
    step(9'd50,  8'd0,   0, 0, 0, 0, 0, 0, 8'h00, 8'h00, 8'h00, "R9");
    step(9'd100, 8'd0,   0, 0, 0, 0, 0, 0, 8'h00, 8'h00, 8'h08, "R9");
    step(9'd100, 8'd96,  0, 0, 0, 0, 0, 0, 8'h00, 8'h00, 8'h18, "R3");
    step(9'd100, 8'd130, 0, 0, 0, 0, 0, 0, 8'h00, 8'h00, 8'h38, "R4");
    step(9'd100, 8'd130, 0, 0, 0, 0, 0, 1, 8'hFF, 8'h00, 8'h00, "R8");
    step(9'd300, 8'd130, 0, 0, 0, 0, 0, 0, 8'h00, 8'h00, 8'h40, "R5");
    step(9'd0,   8'd0,   0, 0, 0, 0, 0, 0, 8'h00, 8'h00, 8'h40, "R5");
    step(9'd128, 8'd0,   0, 0, 0, 0, 0, 0, 8'h00, 8'h00, 8'h68, "R4");
    step(9'd128, 8'd0,   1, 0, 0, 0, 0, 0, 8'h00, 8'h00, 8'hE8, "R6");
    step(9'd128, 8'd0,   0, 1, 0, 0, 0, 1, 8'h80, 8'h00, 8'hE8, "R10");
    step(9'd128, 8'd0,   0, 0, 0, 0, 0, 1, 8'h80, 8'h00, 8'h68, "R8");
    step(9'd128, 8'd0,   0, 1, 0, 0, 0, 0, 8'h00, 8'h00, 8'hE8, "R6");
    step(9'd128, 8'd0,   0, 0, 1, 0, 0, 1, 8'h01, 8'h00, 8'hE9, "R7");
    step(9'd128, 8'd0,   0, 0, 0, 0, 0, 1, 8'hFF, 8'h00, 8'h00, "R8");
    step(9'd128, 8'd0,   0, 0, 0, 1, 0, 0, 8'h00, 8'h00, 8'h02, "R11");
    step(9'd128, 8'd0,   0, 0, 0, 1, 0, 1, 8'h06, 8'h00, 8'h02, "R11");
    step(9'd128, 8'd0,   0, 0, 0, 0, 1, 0, 8'h00, 8'h00, 8'h04, "R11");
    step(9'd128, 8'd0,   0, 0, 0, 0, 0, 0, 8'h00, 8'h00, 8'h00, "R11");
    step(9'd128, 8'd0,   0, 0, 0, 1, 0, 0, 8'h00, 8'h02, 8'h02, "R12");
    step(9'd128, 8'd0,   0, 0, 0, 1, 0, 0, 8'h00, 8'hFD, 8'h02, "R12");
    step(9'd128, 8'd0,   0, 0, 1, 1, 0, 0, 8'h00, 8'hFD, 8'h03, "R12");
    step(9'd128, 8'd0,   0, 0, 0, 1, 0, 1, 8'h00, 8'hFD, 8'h03, "R8");
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule